// File: doc/BRIEF.md
# Dual-Bank Floppy Controller Host Front End

This block is the processor-facing register layer of a floppy disk controller whose three host ports can be reached through either of two I/O windows. One window sits at 0x90 and the other at 0xC8. Each window offers a status port, a data port and a control port, with ports two addresses apart. A mode register at 0xBE picks which window answers and which media density is active. The mode bit that picks the window also picks which interrupt line and which DMA-ready output are used.

The command engine and the media model sit outside this block. The engine presents its main status byte, its next result byte and a DMA-arm pulse. It takes accepted command bytes, result-pop strobes and a status-clear pulse. When it pulses command completion, the front end raises an interrupt after a fixed delay. The interrupt stays up until the engine clears it. An optional per-drive speed register at 0x4BE is enabled by a configuration input.

Top module: `fdc_host_if`

## Requirements
- R1: After reset, the mode register reads 0x0B, `media_hd` is 1, and both interrupt lines and both DMA-ready outputs are low.
- R2: An access to 0x90/0x92/0x94 while mode bit 0 is 0, or to 0xC8/0xCA/0xCC while mode bit 0 is 1, is ignored. Such a write changes nothing, and such a read returns 0xFF. Reads of ports the block does not own also return 0xFF.
- R3: A data-port write in the live window is passed on only when `ctrl_status` bit 7 (request for master) is 1 and bit 6 (direction) is 0. In that case `cmd_wr_stb` is high for one cycle after the write edge, with the byte on `cmd_wr_data`. Any other data-port write produces no strobe.
- R4: A data-port read in the live window with status bits 7 and 6 both 1 returns `res_byte`, asserts `res_pop` in that cycle, and remembers the byte. Any other live data-port read returns the remembered byte (0x00 after reset) and does not assert `res_pop`.
- R5: A live control-port write whose bit 4 differs from bit 4 of the previous control write gives a one-cycle `stat_clr` pulse and drops DMA ready. Every live control write stores its value for the next comparison. Bit 4 starts at 0.
- R6: A live read of offset 0 returns `ctrl_status`. A live read of offset 4 returns 0x40.
- R7: A write to 0xBE stores the mode. A read of 0xBE returns 0x08 ORed with mode bits 1:0. `media_hd` follows mode bit 1.
- R8: When `cmd_done` is sampled while no delay is running, the interrupt request rises exactly 512 cycles after that edge. A `cmd_done` during the delay restarts nothing. `int_clr` drops the request, and reset clears both the request and the delay.
- R9: A pending interrupt drives `irq11` when mode bit 0 is 1 and `irq10` when it is 0. The two lines are never high together.
- R10: DMA ready is set by `dma_arm`. It appears on `dma_rdy_hd` when mode bit 0 is 1 and on `dma_rdy_dd` otherwise.
- R11: With `speed_en` high, a write to 0x4BE selects the drive given by bits 6:5. If bit 4 of that write is set, bit 0 is stored as that drive's speed flag. A read returns 0xF0 ORed with the selected drive's flag. With `speed_en` low, the port reads 0xFF and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, combinational for the current access |
| speed_en | input | 1 | Enables the speed register port |
| ctrl_status | input | 8 | Engine main status byte (bit 7 request for master, bit 6 direction) |
| res_byte | input | 8 | Next result byte offered by the engine |
| res_pop | output | 1 | Result byte consumed this cycle |
| cmd_wr_stb | output | 1 | Accepted command byte valid |
| cmd_wr_data | output | 8 | Accepted command byte |
| cmd_done | input | 1 | Command completion pulse |
| int_clr | input | 1 | Clears the pending interrupt |
| dma_arm | input | 1 | Sets DMA ready |
| stat_clr | output | 1 | Status-reset pulse to the engine |
| irq10 | output | 1 | Interrupt line used when mode bit 0 is 0 |
| irq11 | output | 1 | Interrupt line used when mode bit 0 is 1 |
| dma_rdy_hd | output | 1 | DMA ready, high-density channel |
| dma_rdy_dd | output | 1 | DMA ready, double-density channel |
| media_hd | output | 1 | High-density media selected |

## Verification
The properties take some things for granted about the inputs. The host never raises `io_rd` and `io_wr` in the same cycle. `ctrl_status` holds steady for the whole of each access. `int_clr` never coincides with the cycle in which the delay expires. The interrupt checks also assume that only `int_clr` or reset brings the request down.

The stimulus respects all of this by construction. It issues one strobe per task call, changes the status byte only between accesses, and pulses `int_clr` only after the delay has visibly run out. It never touches the mode register while checking the fall of an interrupt.

// File: rtl/fdc_hif_pkg.sv
package fdc_hif_pkg;

  localparam logic [15:0] BANK_HD_BASE = 16'h0090;
  localparam logic [15:0] BANK_DD_BASE = 16'h00C8;
  localparam logic [15:0] MODE_PORT    = 16'h00BE;
  localparam logic [15:0] SPEED_PORT   = 16'h04BE;

  localparam int unsigned STAT_RQM_BIT = 7;
  localparam int unsigned STAT_DIO_BIT = 6;
  localparam int unsigned CTRL_RST_BIT = 4;

  localparam int unsigned SPD_SEL_LSB  = 5;
  localparam int unsigned SPD_SEL_W    = 2;
  localparam int unsigned SPD_STORE_BIT = 4;
  localparam int unsigned SPD_FLAG_BIT = 0;

  localparam logic [7:0] RD_FLOAT      = 8'hFF;
  localparam logic [7:0] RD_CTRL_CONST = 8'h40;
  localparam logic [5:0] RD_MODE_HIGH  = 6'b000010;
  localparam logic [3:0] RD_SPD_HIGH   = 4'hF;

  typedef enum logic [2:0] {
    PSEL_NONE,
    PSEL_STATUS,
    PSEL_DATA,
    PSEL_CTRL,
    PSEL_MODE,
    PSEL_SPEED
  } port_sel_e;

endpackage

// File: rtl/fdc_port_decode.sv
module fdc_port_decode
  import fdc_hif_pkg::*;
(
  input  logic [15:0] addr_i,
  input  logic        live_bank_i,
  input  logic        speed_en_i,
  output port_sel_e   sel_o
);

  logic [1:0] bank_hit;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic [15:0] BASE = (b == 1) ? BANK_HD_BASE : BANK_DD_BASE;
    assign bank_hit[b] = (addr_i[15:3] == BASE[15:3]) && !addr_i[0] &&
                         (addr_i[2:1] != 2'b11);
  end

  always_comb begin
    sel_o = PSEL_NONE;
    if (|bank_hit) begin
      if (addr_i[4] == live_bank_i) begin
        unique case (addr_i[2:1])
          2'b00:   sel_o = PSEL_STATUS;
          2'b01:   sel_o = PSEL_DATA;
          2'b10:   sel_o = PSEL_CTRL;
          default: sel_o = PSEL_NONE;
        endcase
      end
    end else if (addr_i == MODE_PORT) begin
      sel_o = PSEL_MODE;
    end else if ((addr_i == SPEED_PORT) && speed_en_i) begin
      sel_o = PSEL_SPEED;
    end
  end

endmodule

// File: rtl/fdc_irq_delay.sv
module fdc_irq_delay #(
  parameter int unsigned IRQ_DELAY = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic clr_i,
  output logic pend_o
);

  localparam int unsigned CNT_W = (IRQ_DELAY > 2) ? $clog2(IRQ_DELAY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(IRQ_DELAY - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             pend_q, pend_d;
  logic             expire;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    expire = 1'b0;
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end
    pend_d = expire | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/fdc_speed_regs.sv
module fdc_speed_regs
  import fdc_hif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic       flag_o
);

  localparam int unsigned N_DRIVES = 1 << SPD_SEL_W;

  logic [SPD_SEL_W-1:0] sel_q, sel_d;
  logic [N_DRIVES-1:0]  flag_q, flag_d;
  logic [SPD_SEL_W-1:0] wr_sel;
  logic                 unused_wbits;

  assign wr_sel       = wdata_i[SPD_SEL_LSB +: SPD_SEL_W];
  assign unused_wbits = ^{wdata_i[7], wdata_i[3:1]};

  assign sel_d = wr_i ? wr_sel : sel_q;

  for (genvar i = 0; i < N_DRIVES; i++) begin : g_drv
    always_comb begin
      flag_d[i] = flag_q[i];
      if (wr_i && wdata_i[SPD_STORE_BIT] && (wr_sel == SPD_SEL_W'(i))) begin
        flag_d[i] = wdata_i[SPD_FLAG_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      flag_q <= '0;
    end else begin
      sel_q  <= sel_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q[sel_q];

endmodule

// File: rtl/fdc_host_if.sv
module fdc_host_if
  import fdc_hif_pkg::*;
#(
  parameter int unsigned IRQ_DELAY = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic        speed_en,
  input  logic [7:0]  ctrl_status,
  input  logic [7:0]  res_byte,
  output logic        res_pop,
  output logic        cmd_wr_stb,
  output logic [7:0]  cmd_wr_data,
  input  logic        cmd_done,
  input  logic        int_clr,
  input  logic        dma_arm,
  output logic        stat_clr,
  output logic        irq10,
  output logic        irq11,
  output logic        dma_rdy_hd,
  output logic        dma_rdy_dd,
  output logic        media_hd
);

  port_sel_e  sel;
  logic [1:0] mode_q, mode_d;
  logic       ctrl_bit_q, ctrl_bit_d;
  logic [7:0] last_q, last_d;
  logic       cw_q, cw_d;
  logic [7:0] cwd_q, cwd_d;
  logic       sclr_q, sclr_d;
  logic       dma_q, dma_d;
  logic       rqm, dio;
  logic       data_wr_ok, data_rd_pop, ctrl_wr, ctrl_flip, mode_wr, spd_wr;
  logic       spd_flag, int_pend;

  fdc_port_decode u_dec (
    .addr_i      (io_addr),
    .live_bank_i (mode_q[0]),
    .speed_en_i  (speed_en),
    .sel_o       (sel)
  );

  fdc_speed_regs u_spd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (spd_wr),
    .wdata_i (io_wdata),
    .flag_o  (spd_flag)
  );

  fdc_irq_delay #(.IRQ_DELAY(IRQ_DELAY)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (cmd_done),
    .clr_i   (int_clr),
    .pend_o  (int_pend)
  );

  assign rqm = ctrl_status[STAT_RQM_BIT];
  assign dio = ctrl_status[STAT_DIO_BIT];

  assign data_wr_ok  = io_wr && (sel == PSEL_DATA) && rqm && !dio;
  assign data_rd_pop = io_rd && (sel == PSEL_DATA) && rqm && dio;
  assign ctrl_wr     = io_wr && (sel == PSEL_CTRL);
  assign ctrl_flip   = ctrl_wr && (io_wdata[CTRL_RST_BIT] != ctrl_bit_q);
  assign mode_wr     = io_wr && (sel == PSEL_MODE);
  assign spd_wr      = io_wr && (sel == PSEL_SPEED);

  always_comb begin
    mode_d     = mode_wr ? io_wdata[1:0] : mode_q;
    ctrl_bit_d = ctrl_wr ? io_wdata[CTRL_RST_BIT] : ctrl_bit_q;
    last_d     = data_rd_pop ? res_byte : last_q;
    cw_d       = data_wr_ok;
    cwd_d      = data_wr_ok ? io_wdata : cwd_q;
    sclr_d     = ctrl_flip;
    if (ctrl_flip) begin
      dma_d = 1'b0;
    end else if (dma_arm) begin
      dma_d = 1'b1;
    end else begin
      dma_d = dma_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= 2'b11;
      ctrl_bit_q <= 1'b0;
      last_q     <= 8'h00;
      cw_q       <= 1'b0;
      cwd_q      <= 8'h00;
      sclr_q     <= 1'b0;
      dma_q      <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      ctrl_bit_q <= ctrl_bit_d;
      last_q     <= last_d;
      cw_q       <= cw_d;
      cwd_q      <= cwd_d;
      sclr_q     <= sclr_d;
      dma_q      <= dma_d;
    end
  end

  always_comb begin
    unique case (sel)
      PSEL_STATUS: io_rdata = ctrl_status;
      PSEL_DATA:   io_rdata = data_rd_pop ? res_byte : last_q;
      PSEL_CTRL:   io_rdata = RD_CTRL_CONST;
      PSEL_MODE:   io_rdata = {RD_MODE_HIGH, mode_q};
      PSEL_SPEED:  io_rdata = {RD_SPD_HIGH, 3'b000, spd_flag};
      default:     io_rdata = RD_FLOAT;
    endcase
  end

  assign res_pop     = data_rd_pop;
  assign cmd_wr_stb  = cw_q;
  assign cmd_wr_data = cwd_q;
  assign stat_clr    = sclr_q;
  assign irq11       = int_pend & mode_q[0];
  assign irq10       = int_pend & ~mode_q[0];
  assign dma_rdy_hd  = dma_q & mode_q[0];
  assign dma_rdy_dd  = dma_q & ~mode_q[0];
  assign media_hd    = mode_q[1];

endmodule

// File: rtl/fdc_host_if_chk.sv
module fdc_host_if_chk #(
  parameter int unsigned DELAY = 512
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic        io_wr,
  input logic        io_rd,
  input logic [7:0]  io_rdata,
  input logic [7:0]  ctrl_status,
  input logic        cmd_wr_stb,
  input logic        stat_clr,
  input logic        cmd_done,
  input logic        int_clr,
  input logic        irq10,
  input logic        irq11,
  input logic        dma_rdy_hd,
  input logic        dma_rdy_dd
);

  localparam int unsigned CW = $clog2(DELAY) + 1;

  logic          chk_busy;
  logic [CW-1:0] chk_cnt;
  logic          irq_any;

  assign irq_any = irq10 | irq11;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_busy <= 1'b0;
      chk_cnt  <= '0;
    end else if (chk_busy) begin
      if (chk_cnt == CW'(DELAY)) begin
        chk_busy <= 1'b0;
      end else begin
        chk_cnt <= chk_cnt + 1'b1;
      end
    end else if (cmd_done) begin
      chk_busy <= 1'b1;
      chk_cnt  <= 1;
    end
  end

  assert_one_irq_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq10 && irq11));

  assert_one_dma_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_rdy_hd && dma_rdy_dd));

  assert_write_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_stb |-> $past(io_wr && ctrl_status[7] && !ctrl_status[6]));

  assert_ctrl_const_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && ((io_addr == 16'h0094) || (io_addr == 16'h00CC)) && (io_rdata != 8'hFF))
      |-> (io_rdata == 8'h40));

  assert_mode_format_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (io_addr == 16'h00BE)) |-> (io_rdata[7:2] == 6'b000010));

  assert_statclr_drops_dma_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |-> ($past(io_wr) && !dma_rdy_hd && !dma_rdy_dd));

  assert_irq_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_any) |-> $past(chk_busy && (chk_cnt == CW'(DELAY))));

  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_any) |-> $past(int_clr));

endmodule

bind fdc_host_if fdc_host_if_chk #(.DELAY(IRQ_DELAY)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_addr     (io_addr),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_rdata    (io_rdata),
  .ctrl_status (ctrl_status),
  .cmd_wr_stb  (cmd_wr_stb),
  .stat_clr    (stat_clr),
  .cmd_done    (cmd_done),
  .int_clr     (int_clr),
  .irq10       (irq10),
  .irq11       (irq11),
  .dma_rdy_hd  (dma_rdy_hd),
  .dma_rdy_dd  (dma_rdy_dd)
);

// File: tb/sim_fdc_host_if.sv
`timescale 1ns/1ps
module sim_fdc_host_if;

  localparam int DLY = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        speed_en = 1'b0;
  logic [7:0]  ctrl_status = 8'h00;
  logic [7:0]  res_byte = 8'h00;
  logic        res_pop, cmd_wr_stb, stat_clr;
  logic [7:0]  cmd_wr_data;
  logic        cmd_done = 1'b0, int_clr = 1'b0, dma_arm = 1'b0;
  logic        irq10, irq11, dma_rdy_hd, dma_rdy_dd, media_hd;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fdc_host_if #(.IRQ_DELAY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .speed_en(speed_en),
    .ctrl_status(ctrl_status), .res_byte(res_byte), .res_pop(res_pop),
    .cmd_wr_stb(cmd_wr_stb), .cmd_wr_data(cmd_wr_data), .cmd_done(cmd_done),
    .int_clr(int_clr), .dma_arm(dma_arm), .stat_clr(stat_clr), .irq10(irq10),
    .irq11(irq11), .dma_rdy_hd(dma_rdy_hd), .dma_rdy_dd(dma_rdy_dd),
    .media_hd(media_hd)
  );

  // reference model state
  bit [1:0] m_mode;
  bit       m_c4, m_cw, m_sc, m_dma, m_int, m_busy;
  bit [7:0] m_last, m_cwd;
  bit [1:0] m_spsel;
  bit [3:0] m_flag;
  int       m_cnt;

  // 1: window at 0x90, 0: window at 0xC8, -1: not a window port
  function automatic int window_of(input logic [15:0] a);
    case (a)
      16'h0090, 16'h0092, 16'h0094: return 1;
      16'h00C8, 16'h00CA, 16'h00CC: return 0;
      default: return -1;
    endcase
  endfunction

  function automatic bit live(input logic [15:0] a);
    int w;
    w = window_of(a);
    return (w >= 0) && (w == int'(m_mode[0]));
  endfunction

  function automatic bit is_data(input logic [15:0] a);
    return (a == 16'h0092) || (a == 16'h00CA);
  endfunction

  function automatic bit is_ctrl(input logic [15:0] a);
    return (a == 16'h0094) || (a == 16'h00CC);
  endfunction

  function automatic bit pop_now();
    return io_rd && live(io_addr) && is_data(io_addr) && ctrl_status[7] && ctrl_status[6];
  endfunction

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    if (window_of(a) >= 0) begin
      if (!live(a)) return 8'hFF;
      if (is_data(a)) return (ctrl_status[7] && ctrl_status[6]) ? res_byte : m_last;
      if (is_ctrl(a)) return 8'h40;
      return ctrl_status;
    end
    if (a == 16'h00BE) return {6'b000010, m_mode};
    if ((a == 16'h04BE) && speed_en) return {7'b1111000, m_flag[m_spsel]};
    return 8'hFF;
  endfunction

  function automatic string read_tag(input logic [15:0] a);
    if ((window_of(a) >= 0) && !live(a)) return "R2";
    if (is_data(a)) return "R4";
    if (window_of(a) >= 0) return "R6";
    if (a == 16'h00BE) return "R7";
    if (a == 16'h04BE) return "R11";
    return "R2";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 2'b11; m_c4 = 0; m_cw = 0; m_sc = 0; m_dma = 0; m_int = 0;
      m_busy = 0; m_cnt = 0; m_last = 8'h00; m_cwd = 8'h00; m_spsel = 0; m_flag = 0;
    end else begin
      bit set_int, drop_dma;
      set_int = 0; drop_dma = 0;
      m_cw = 0; m_sc = 0;
      if (pop_now()) m_last = res_byte;
      if (io_wr) begin
        if (live(io_addr) && is_data(io_addr) && ctrl_status[7] && !ctrl_status[6]) begin
          m_cw = 1; m_cwd = io_wdata;
        end
        if (live(io_addr) && is_ctrl(io_addr)) begin
          if (io_wdata[4] != m_c4) begin m_sc = 1; drop_dma = 1; end
          m_c4 = io_wdata[4];
        end
        if (io_addr == 16'h00BE) m_mode = io_wdata[1:0];
        if ((io_addr == 16'h04BE) && speed_en) begin
          m_spsel = io_wdata[6:5];
          if (io_wdata[4]) m_flag[io_wdata[6:5]] = io_wdata[0];
        end
      end
      if (drop_dma) m_dma = 0;
      else if (dma_arm) m_dma = 1;
      if (m_busy) begin
        if (m_cnt == 0) begin set_int = 1; m_busy = 0; end
        else m_cnt = m_cnt - 1;
      end else if (cmd_done) begin
        m_busy = 1; m_cnt = DLY - 1;
      end
      if (int_clr) m_int = 0;
      if (set_int) m_int = 1;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s at %0t: actual %02h expected %02h", tag, $time, act, exp);
    end
  endtask

  // compare against the model on every cycle, away from the clock edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R9", {7'b0, irq11}, {7'b0, m_int && m_mode[0]});
      check("R9", {7'b0, irq10}, {7'b0, m_int && !m_mode[0]});
      check("R10", {7'b0, dma_rdy_hd}, {7'b0, m_dma && m_mode[0]});
      check("R10", {7'b0, dma_rdy_dd}, {7'b0, m_dma && !m_mode[0]});
      check("R7", {7'b0, media_hd}, {7'b0, m_mode[1]});
      check("R3", {7'b0, cmd_wr_stb}, {7'b0, m_cw});
      if (m_cw) check("R3", cmd_wr_data, m_cwd);
      check("R5", {7'b0, stat_clr}, {7'b0, m_sc});
      check("R4", {7'b0, res_pop}, {7'b0, pop_now()});
      if (io_rd) check(read_tag(io_addr), io_rdata, exp_read(io_addr));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1; tick(); io_wr = 0;
  endtask
  task automatic rd(input logic [15:0] a);
    io_addr = a; io_rd = 1; tick(); io_rd = 0;
  endtask
  task automatic pulse_done();  cmd_done = 1; tick(); cmd_done = 0; endtask
  task automatic pulse_clr();   int_clr = 1;  tick(); int_clr = 0;  endtask
  task automatic pulse_arm();   dma_arm = 1;  tick(); dma_arm = 0;  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    @(negedge clk);
    // R1 reset state
    check("R1", {7'b0, media_hd}, 8'h01);
    check("R1", {6'b0, irq10, irq11}, 8'h00);
    check("R1", {6'b0, dma_rdy_hd, dma_rdy_dd}, 8'h00);
    tick();
    rd(16'h00BE);                               // R1: 0x0B
    // R6 status and constant
    ctrl_status = 8'h80; rd(16'h0090); rd(16'h0094);
    // R2 inactive window
    rd(16'h00C8); rd(16'h00CA); rd(16'h00CC); wr(16'h00CA, 8'h33); rd(16'h0123);
    // R3 write gating
    wr(16'h0092, 8'hA5);
    ctrl_status = 8'hC0; wr(16'h0092, 8'h11);
    ctrl_status = 8'h00; wr(16'h0092, 8'h22);
    ctrl_status = 8'h80; wr(16'h0092, 8'h3C);
    // R4 result reads
    ctrl_status = 8'hC0; res_byte = 8'h5A; rd(16'h0092);
    res_byte = 8'h6B; rd(16'h0092);
    ctrl_status = 8'h80; res_byte = 8'h77; rd(16'h0092);
    ctrl_status = 8'h40; rd(16'h0092);
    // R5 control bit 4 toggling
    pulse_arm(); tick();
    wr(16'h0094, 8'h10); tick();
    pulse_arm(); wr(16'h0094, 8'h14); tick();
    wr(16'h0094, 8'h00); tick();
    wr(16'h00CC, 8'h10); tick();                // R2: ignored, no pulse
    wr(16'h0094, 8'h00); tick();
    // R8 delay with a second completion inside the window
    pulse_done();
    repeat (100) tick();
    pulse_done();
    repeat (DLY) tick();
    pulse_clr(); tick();
    // R7 switch to the other window and density
    wr(16'h00BE, 8'hFC); rd(16'h00BE);
    rd(16'h0090); rd(16'h0094); rd(16'h00CC); rd(16'h00C8);
    ctrl_status = 8'h80; wr(16'h00CA, 8'h99);
    ctrl_status = 8'hC0; res_byte = 8'h42; rd(16'h00CA);
    pulse_arm(); tick();
    pulse_done();
    repeat (DLY + 4) tick();                     // R9 on irq10
    wr(16'h00BE, 8'h01); tick();                 // R9 steer to irq11
    wr(16'h00BE, 8'h02); rd(16'h00BE);
    pulse_clr(); tick();
    wr(16'h00BE, 8'h03); rd(16'h00BE);
    // R11 speed register
    rd(16'h04BE); wr(16'h04BE, 8'h31);
    speed_en = 1;
    rd(16'h04BE);
    wr(16'h04BE, 8'h21); rd(16'h04BE);
    wr(16'h04BE, 8'h31); rd(16'h04BE);
    wr(16'h04BE, 8'h51); rd(16'h04BE);
    wr(16'h04BE, 8'h20); rd(16'h04BE);
    wr(16'h04BE, 8'h70); rd(16'h04BE);
    wr(16'h04BE, 8'h30); rd(16'h04BE);
    speed_en = 0; wr(16'h04BE, 8'h51); speed_en = 1; rd(16'h04BE);
    // R8 reset during a running delay
    pulse_done();
    repeat (200) tick();
    rst_n = 0; tick(); tick(); rst_n = 1;
    repeat (DLY + 20) tick();
    rd(16'h00BE);
    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule